// File: doc/BRIEF.md
# Multichannel Serial Audio Output Formatter

The block takes eight decoded audio channels and a few user bits per frame, and drives them onto four serial data lines. Each line carries one stereo pair. A bit clock and a word clock go with the data to a downstream converter. Everything runs from one master clock at 256 times the frame rate. The bit clock is a registered divider output at 64 times the frame rate, so each frame holds 64 bit slots: 32 with the word clock high, followed by 32 with it low.

A two-bit format input chooses right-justified framing, left-justified framing, or left-justified framing with a gated bit clock. Its fourth code holds the block in reset. In master mode the frame counter runs freely and the block drives the word clock. In slave mode a rising edge on the external word clock restarts the frame. Data lines are forced low by the mute input or by the error flag, and the clocks keep running in both cases. The error flag can be made sticky with a hold input.

All outputs change on the same master-clock edge, at the start of a bit slot. In right-justified framing the receiver samples on the rising bit-clock edge. In both left-justified framings it samples on the falling edge, which lies in the middle of the slot.

Top module: `aso_serial_out`

## Requirements
- R1: Data line p (0..3) carries channel 2p while the word clock is high and channel 2p+1 while it is low. A frame lasts 256 master clocks, the word clock is high for the first 128, and the bit clock period is 4 master clocks. Channel k occupies bits [24k+23:24k] of `ch_data_i`.
- R2: `len_i` = 00 takes bits [15:0] of a channel, 01 takes bits [19:0], and 10 or 11 takes bits [23:0]. The taken bits are placed MSB-first at the top of a 24-bit word, the bits below them are zero, and the input bits above them are ignored.
- R3: With `fmt_i` = 00, slots 8..31 of each half-frame carry the word MSB first and slots 0..7 are zero. The bit clock is low for the first two master clocks of each slot, so it falls at every word-clock transition.
- R4: With `fmt_i` = 01, slots 0..23 carry the word MSB first and slots 24..31 are zero. The bit clock is high for the first two master clocks of each slot, so it rises at every word-clock transition.
- R5: With `fmt_i` = 11, data is placed as in R4. The bit clock pulses only in slots 0..23 of each half-frame and stays low in slots 24..31.
- R6: While `fmt_i` = 10, the bit clock, word clock, data lines and user outputs are held low. When any other code is applied, the word clock rises one master clock later and a new frame starts.
- R7: Channel words and `user_i` are captured at each frame start. `user_o` holds the captured value for the whole frame, and input changes within a frame do not affect that frame.
- R8: One cycle after `mute_i` is high, all data lines are low, and the bit and word clocks keep running.
- R9: `err_o` rises one cycle after `err_cause_i` is high. With `hold_err_i` low it falls one cycle after the cause clears. One cycle after `err_o` is high, the data lines are low, and the clocks keep running.
- R10: While `hold_err_i` is high, `err_o` stays high once set. It clears only when the cause is low and `hold_err_i` is low.
- R11: In slave mode (`master_i` = 0), a rising edge on `wclk_i` makes `wclk_o` start a new frame 3 master clocks later, with data for slot 0. `wclk_oe_o` is high one cycle after `master_i` is high and low one cycle after it is low.
- R12: While `rst_ni` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 256 x frame rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Framing select: 00 right-justified, 01 left-justified, 10 hold in reset, 11 gated bit clock |
| master_i | input | 1 | 1: internal word clock; 0: follow `wclk_i` |
| wclk_i | input | 1 | External word clock (slave mode) |
| len_i | input | 2 | Input sample length: 00 16-bit, 01 20-bit, 1x 24-bit |
| ch_data_i | input | 192 | Eight channel samples, channel k at [24k+23:24k] |
| user_i | input | 4 | User bits for the next frame |
| mute_i | input | 1 | Forces data lines low |
| err_cause_i | input | 1 | Error condition from the decoder (no input or sync loss) |
| hold_err_i | input | 1 | Makes the error flag sticky |
| bclk_o | output | 1 | Bit clock, 64 x frame rate |
| wclk_o | output | 1 | Word clock, high during the left half-frame |
| wclk_oe_o | output | 1 | Word clock drive enable, high in master mode |
| data_o | output | 4 | Serial data, one line per stereo pair |
| user_o | output | 4 | User bits captured for the current frame |
| err_o | output | 1 | Error flag |

## Verification
The bench sweeps every framing code against every input length, using two channel patterns with nonzero upper bits. It compares each master clock of a frame with slot arithmetic done in the bench. A slot offset error, a wrong shift for short samples, or swapped left and right channels would each show up as single-bit mismatches within the frame. The edge-polarity and gating checks catch a bit clock whose phase is inverted or that keeps running through the padding slots. Separate sequences exercise exit from the reset code on the next clock, user-bit capture against a mid-frame change, and mute and error with the clocks still running. The sticky flag is checked both with the cause still present and after it clears. Slave realignment is checked from two arbitrary phases, so a design that ignored the external edge would place the word-clock fall at the wrong cycle.

// File: rtl/aso_pkg.sv
`timescale 1ns/1ps
package aso_pkg;
  typedef enum logic [1:0] {
    FMT_RJ   = 2'b00,
    FMT_LJ   = 2'b01,
    FMT_RST  = 2'b10,
    FMT_GATE = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    LEN_16  = 2'b00,
    LEN_20  = 2'b01,
    LEN_24  = 2'b10,
    LEN_24X = 2'b11
  } len_e;
endpackage

// File: rtl/aso_timing.sv
`timescale 1ns/1ps
// Frame position counter {half, slot, phase}; reports next-cycle position.
module aso_timing #(
  parameter int SLOT_N   = 32,
  parameter int MCLK_DIV = 4,
  localparam int SLOT_W = $clog2(SLOT_N),
  localparam int DIV_W  = $clog2(MCLK_DIV),
  localparam int POS_W  = 1 + SLOT_W + DIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_i,
  input  logic              slave_i,
  input  logic              wclk_i,
  output logic              frame_start_o,
  output logic              half_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [DIV_W-1:0]  phase_o
);
  logic [POS_W-1:0] pos_q, pos_nxt;
  logic [2:0]       sync_q;
  logic             rise;

  assign rise    = sync_q[1] & ~sync_q[2];
  assign pos_nxt = (slave_i && rise) ? '0 : pos_q + POS_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '1;
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], wclk_i};
      // parked on last position so release starts a frame
      pos_q  <= stop_i ? '1 : pos_nxt;
    end
  end

  assign frame_start_o = !stop_i && (pos_nxt == '0);
  assign half_o        = pos_nxt[POS_W-1];
  assign slot_o        = pos_nxt[DIV_W +: SLOT_W];
  assign phase_o       = pos_nxt[DIV_W-1:0];
endmodule

// File: rtl/aso_err.sv
`timescale 1ns/1ps
module aso_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cause_i,
  input  logic hold_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= cause_i | (err_q & hold_i);
  end

  assign err_o = err_q;
endmodule

// File: rtl/aso_lane.sv
`timescale 1ns/1ps
// Selects the serial bit of one stereo pair for a given slot.
module aso_lane
  import aso_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_N   = 32,
  localparam int SLOT_W = $clog2(SLOT_N),
  localparam int IDX_W  = $clog2(SAMPLE_W)
) (
  input  fmt_e                fmt_i,
  input  logic                half_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                bit_o
);
  logic [SAMPLE_W-1:0] word;
  logic [IDX_W-1:0]    rj_idx, lj_idx;

  assign word   = half_i ? right_i : left_i;
  assign rj_idx = IDX_W'(SLOT_N - 1 - int'(slot_i));
  assign lj_idx = IDX_W'(SAMPLE_W - 1 - int'(slot_i));

  always_comb begin
    bit_o = 1'b0;
    case (fmt_i)
      FMT_RJ:   if (int'(slot_i) >= SLOT_N - SAMPLE_W) bit_o = word[rj_idx];
      FMT_LJ,
      FMT_GATE: if (int'(slot_i) < SAMPLE_W) bit_o = word[lj_idx];
      default:  bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/aso_serial_out.sv
`timescale 1ns/1ps
module aso_serial_out
  import aso_pkg::*;
#(
  parameter int N_PAIR   = 4,
  parameter int SAMPLE_W = 24,
  parameter int SLOT_N   = 32,
  parameter int MCLK_DIV = 4,
  parameter int USER_W   = 4,
  localparam int N_CH   = 2 * N_PAIR,
  localparam int SLOT_W = $clog2(SLOT_N),
  localparam int DIV_W  = $clog2(MCLK_DIV)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               fmt_i,
  input  logic                     master_i,
  input  logic                     wclk_i,
  input  logic [1:0]               len_i,
  input  logic [N_CH*SAMPLE_W-1:0] ch_data_i,
  input  logic [USER_W-1:0]        user_i,
  input  logic                     mute_i,
  input  logic                     err_cause_i,
  input  logic                     hold_err_i,
  output logic                     bclk_o,
  output logic                     wclk_o,
  output logic                     wclk_oe_o,
  output logic [N_PAIR-1:0]        data_o,
  output logic [USER_W-1:0]        user_o,
  output logic                     err_o
);
  fmt_e fmt;
  logic stop;
  assign fmt  = fmt_e'(fmt_i);
  assign stop = (fmt == FMT_RST);

  logic              frame_start, half;
  logic [SLOT_W-1:0] slot;
  logic [DIV_W-1:0]  phase;

  aso_timing #(.SLOT_N(SLOT_N), .MCLK_DIV(MCLK_DIV)) u_timing (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .stop_i        (stop),
    .slave_i       (!master_i),
    .wclk_i        (wclk_i),
    .frame_start_o (frame_start),
    .half_o        (half),
    .slot_o        (slot),
    .phase_o       (phase)
  );

  logic err_q;
  aso_err u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cause_i (err_cause_i),
    .hold_i  (hold_err_i),
    .err_o   (err_q)
  );

  // per-channel capture, MSB-aligned into the word
  logic [N_CH*SAMPLE_W-1:0] word_d;
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [SAMPLE_W-1:0] lane_in, placed, word_q;
    assign lane_in = ch_data_i[c*SAMPLE_W +: SAMPLE_W];
    always_comb begin
      case (len_e'(len_i))
        LEN_16:  placed = lane_in << (SAMPLE_W - 16);
        LEN_20:  placed = lane_in << (SAMPLE_W - 20);
        default: placed = lane_in;
      endcase
    end
    assign word_d[c*SAMPLE_W +: SAMPLE_W] = frame_start ? placed : word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else         word_q <= word_d[c*SAMPLE_W +: SAMPLE_W];
    end
  end

  logic [N_PAIR-1:0] lane_bit;
  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    aso_lane #(.SAMPLE_W(SAMPLE_W), .SLOT_N(SLOT_N)) u_lane (
      .fmt_i   (fmt),
      .half_i  (half),
      .slot_i  (slot),
      .left_i  (word_d[(2*p)*SAMPLE_W +: SAMPLE_W]),
      .right_i (word_d[(2*p+1)*SAMPLE_W +: SAMPLE_W]),
      .bit_o   (lane_bit[p])
    );
  end

  logic [USER_W-1:0] user_q, user_d;
  assign user_d = frame_start ? user_i : user_q;

  logic phase_hi, bclk_d;
  assign phase_hi = (phase >= DIV_W'(MCLK_DIV / 2));

  always_comb begin
    case (fmt)
      FMT_RJ:   bclk_d = phase_hi;
      FMT_LJ:   bclk_d = !phase_hi;
      FMT_GATE: bclk_d = !phase_hi && (int'(slot) < SAMPLE_W);
      default:  bclk_d = 1'b0;
    endcase
  end

  logic              bclk_q, wclk_q, oe_q;
  logic [N_PAIR-1:0] data_q;
  logic [USER_W-1:0] user_o_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      user_q   <= '0;
      user_o_q <= '0;
      bclk_q   <= 1'b0;
      wclk_q   <= 1'b0;
      oe_q     <= 1'b0;
      data_q   <= '0;
    end else begin
      user_q   <= user_d;
      user_o_q <= stop ? '0 : user_d;
      bclk_q   <= bclk_d;
      wclk_q   <= stop ? 1'b0 : !half;
      oe_q     <= master_i;
      data_q   <= (mute_i || err_q || stop) ? '0 : lane_bit;
    end
  end

  assign bclk_o    = bclk_q;
  assign wclk_o    = wclk_q;
  assign wclk_oe_o = oe_q;
  assign data_o    = data_q;
  assign user_o    = user_o_q;
  assign err_o     = err_q;
endmodule

// File: rtl/aso_chk.sv
`timescale 1ns/1ps
module aso_chk #(
  parameter int N_PAIR = 4,
  parameter int USER_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        fmt_i,
  input logic              master_i,
  input logic              mute_i,
  input logic              err_cause_i,
  input logic              hold_err_i,
  input logic              bclk_o,
  input logic              wclk_o,
  input logic              wclk_oe_o,
  input logic [N_PAIR-1:0] data_o,
  input logic [USER_W-1:0] user_o,
  input logic              err_o
);
  logic [1:0] age_q;
  logic       settled;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end
  assign settled = (age_q == 2'd3);

  assert_mute_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_i |=> (data_o == '0));

  assert_err_mute_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (data_o == '0));

  assert_err_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cause_i |=> err_o);

  assert_err_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_cause_i && !hold_err_i) |=> !err_o);

  assert_err_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && hold_err_i) |=> err_o);

  assert_rst_fmt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == 2'b10) |=> (!bclk_o && !wclk_o && data_o == '0 && user_o == '0));

  assert_rj_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && master_i && $past(master_i) && $past(fmt_i) == 2'b00 &&
     $past(fmt_i, 2) == 2'b00 && wclk_o != $past(wclk_o))
    |-> (!bclk_o && $past(bclk_o)));

  assert_lj_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && master_i && $past(master_i) && $past(fmt_i[0]) && $past(fmt_i[0], 2) &&
     $past(fmt_i) == $past(fmt_i, 2) && wclk_o != $past(wclk_o))
    |-> (bclk_o && !$past(bclk_o)));

  assert_oe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |=> wclk_oe_o);
endmodule

bind aso_serial_out aso_chk #(.N_PAIR(N_PAIR), .USER_W(USER_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fmt_i       (fmt_i),
  .master_i    (master_i),
  .mute_i      (mute_i),
  .err_cause_i (err_cause_i),
  .hold_err_i  (hold_err_i),
  .bclk_o      (bclk_o),
  .wclk_o      (wclk_o),
  .wclk_oe_o   (wclk_oe_o),
  .data_o      (data_o),
  .user_o      (user_o),
  .err_o       (err_o)
);

// File: tb/tb_aso_serial_out.sv
`timescale 1ns/1ps
module tb_aso_serial_out;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   fmt = 2'b01;
  logic         master = 1'b1;
  logic         wclk_in = 1'b0;
  logic [1:0]   len = 2'b10;
  logic [191:0] ch_data;
  logic [3:0]   user_in = 4'h0;
  logic         mute = 1'b0;
  logic         cause = 1'b0;
  logic         hold = 1'b0;
  logic         bclk, wclk, wclk_oe, err;
  logic [3:0]   data, user_out;

  logic [23:0] ch [8];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always_comb
    for (int k = 0; k < 8; k++) ch_data[k*24 +: 24] = ch[k];

  aso_serial_out dut (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .master_i(master), .wclk_i(wclk_in),
    .len_i(len), .ch_data_i(ch_data), .user_i(user_in), .mute_i(mute),
    .err_cause_i(cause), .hold_err_i(hold), .bclk_o(bclk), .wclk_o(wclk),
    .wclk_oe_o(wclk_oe), .data_o(data), .user_o(user_out), .err_o(err)
  );

  function automatic logic [23:0] place(logic [23:0] v, logic [1:0] l);
    case (l)
      2'b00:   return {v[15:0], 8'h00};
      2'b01:   return {v[19:0], 4'h0};
      default: return v;
    endcase
  endfunction

  function automatic logic exp_bit(logic [1:0] f, logic [23:0] w, int slot);
    if (f == 2'b00) return (slot >= 8) ? w[31-slot] : 1'b0;
    if (f == 2'b10) return 1'b0;
    return (slot < 24) ? w[23-slot] : 1'b0;
  endfunction

  function automatic logic exp_bclk(logic [1:0] f, int slot, int ph);
    case (f)
      2'b00:   return ph >= 2;
      2'b01:   return ph < 2;
      2'b11:   return (ph < 2) && (slot < 24);
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic prev;
    prev = wclk;
    forever begin
      @(negedge clk);
      if (wclk && !prev) break;
      prev = wclk;
    end
  endtask

  task automatic set_pattern(int seed);
    for (int k = 0; k < 8; k++) ch[k] = 24'(32'h9E3779B9 * (k + 1 + seed * 8) + seed);
  endtask

  // checks every master clock of one frame against slot arithmetic
  task automatic check_frame(logic [1:0] f, logic [1:0] l, bit quiet, string req);
    logic [3:0] ed, eu;
    int act, exp;
    eu = user_in;
    wait_rise();
    for (int c = 0; c < 256; c++) begin
      int half, slot, ph;
      if (c > 0) @(negedge clk);
      half = c / 128;
      slot = (c / 4) % 32;
      ph   = c % 4;
      for (int p = 0; p < 4; p++)
        ed[p] = quiet ? 1'b0 : exp_bit(f, place(ch[2*p+half], l), slot);
      act = {22'd0, bclk, wclk, data, user_out};
      exp = {22'd0, exp_bclk(f, slot, ph), (half == 0), ed, eu};
      chk(act == exp, req, $sformatf("frame c=%0d {bclk,wclk,data,user}", c), act, exp);
    end
  endtask

  function automatic logic [3:0] slot0_bits(logic [1:0] l);
    logic [3:0] r;
    for (int p = 0; p < 4; p++) r[p] = place(ch[2*p], l)[23];
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    set_pattern(0);
    repeat (3) @(negedge clk);
    // R12: outputs low in reset
    chk({bclk, wclk, wclk_oe, data, user_out, err} == 12'h0, "R12", "reset outputs",
        {bclk, wclk, wclk_oe, data, user_out, err}, 0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R7: every format x length x pattern
    for (int fi = 0; fi < 3; fi++) begin
      for (int li = 0; li < 3; li++) begin
        for (int pat = 0; pat < 2; pat++) begin
          logic [1:0] f;
          f = (fi == 0) ? 2'b00 : (fi == 1) ? 2'b01 : 2'b11;
          @(negedge clk);
          fmt = f;
          len = 2'(li);
          user_in = 4'(li * 5 + pat * 3 + fi);
          set_pattern(fi * 6 + li * 2 + pat + 1);
          wait_rise();
          check_frame(f, 2'(li), 1'b0,
                      (fi == 0) ? "R1 R2 R3" : (fi == 1) ? "R1 R2 R4" : "R1 R2 R5");
        end
      end
    end

    // R7: change inputs mid-frame, output keeps captured value
    fmt = 2'b01; len = 2'b10;
    user_in = 4'h5;
    wait_rise();
    wait_rise();
    @(negedge clk);
    user_in = 4'hA;
    repeat (100) @(negedge clk);
    chk(user_out == 4'h5, "R7", "user mid-frame", user_out, 4'h5);
    wait_rise();
    chk(user_out == 4'hA, "R7", "user next frame", user_out, 4'hA);

    // R8: mute
    mute = 1'b1;
    check_frame(2'b01, 2'b10, 1'b1, "R8");
    mute = 1'b0;

    // R9: error follows cause
    @(negedge clk);
    cause = 1'b1;
    @(negedge clk);
    chk(err == 1'b1, "R9", "err set", err, 1);
    check_frame(2'b01, 2'b10, 1'b1, "R9");
    @(negedge clk);
    cause = 1'b0;
    @(negedge clk);
    chk(err == 1'b0, "R9", "err clear", err, 0);
    check_frame(2'b01, 2'b10, 1'b0, "R9");

    // R10: sticky hold
    @(negedge clk);
    hold = 1'b1; cause = 1'b1;
    @(negedge clk);
    cause = 1'b0;
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R10", "held after cause cleared", err, 1);
    cause = 1'b1;
    @(negedge clk);
    hold = 1'b0;
    repeat (3) @(negedge clk);
    chk(err == 1'b1, "R10", "cause still present", err, 1);
    cause = 1'b0;
    @(negedge clk);
    chk(err == 1'b0, "R10", "cleared", err, 0);

    // R6: reset code holds outputs low, release starts frame next cycle
    fmt = 2'b10;
    user_in = 4'h9;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if ({bclk, wclk, data, user_out} != 10'h0 || i == 299)
        chk({bclk, wclk, data, user_out} == 10'h0, "R6", "held low",
            {bclk, wclk, data, user_out}, 0);
    end
    set_pattern(40);
    len = 2'b01;
    fmt = 2'b01;
    @(negedge clk);
    chk({bclk, wclk, data, user_out} == {2'b11, slot0_bits(2'b01), 4'h9}, "R6", "release",
        {bclk, wclk, data, user_out}, {2'b11, slot0_bits(2'b01), 4'h9});

    // R11: slave realignment from two phases
    len = 2'b10;
    master = 1'b0;
    repeat (2) @(negedge clk);
    chk(wclk_oe == 1'b0, "R11", "oe in slave", wclk_oe, 0);
    for (int t = 0; t < 2; t++) begin
      repeat (77 + t * 50) @(negedge clk);
      wclk_in = 1'b1;
      repeat (3) @(negedge clk);
      chk({wclk, data} == {1'b1, slot0_bits(2'b10)}, "R11", "realign slot 0",
          {wclk, data}, {1'b1, slot0_bits(2'b10)});
      repeat (127) @(negedge clk);
      chk(wclk == 1'b1, "R11", "last high cycle", wclk, 1);
      @(negedge clk);
      chk(wclk == 1'b0, "R11", "fall after 128", wclk, 0);
      wclk_in = 1'b0;
    end
    master = 1'b1;
    @(negedge clk);
    chk(wclk_oe == 1'b1, "R11", "oe in master", wclk_oe, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule